// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a general-purpose I/O port of 32 pins behind a small word-addressed register bus. Software sets a direction per pin, drives output levels, reads back the synchronized pad levels and receives interrupts from selected pins. The port drives a value/enable pair per pin toward an external tri-state pad cell. It also produces one combined interrupt line.

Each pin has a 2-bit detection code: low level, high level, rising edge or falling edge. A separate per-pin both-edges bit overrides that code. Detected events set sticky status bits whether or not the pin is enabled in the mask. Software clears a status bit by writing 1 to its position. Three alias addresses set, clear or invert selected output bits in one bus write, so no read-modify-write sequence is needed. Pad inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

Bus writes take effect at the clock edge where `bus_we` is high. Read data is registered and appears the cycle after the address is presented. Reads have no side effects.

Top module: `gpio_irq_port`

## Requirements
- R1: While and after synchronous reset, every register is 0: `pad_out`, `pad_oe`, `irq` and `bus_rdata` all read 0.
- R2: A write to address 1 (direction) loads `pad_oe` on that edge. A bit value of 1 makes the pin an output and 0 makes it an input. `pad_out` always equals the stored output data.
- R3: Address 0 loads the output data directly. Address 8 ORs the write mask into it, address 9 clears the masked bits and address 10 inverts the masked bits. Bits whose mask bit is 0 keep their value.
- R4: A read of address 0 returns, per pin, the stored output bit when the pin is an output and the synchronized pad level when it is an input.
- R5: Address 2 returns the synchronized level of every pad whatever its direction. A pad change is visible after two clock edges.
- R6: Pin n uses a 2-bit detection code. For n < 16 the code sits at bits [2n+1:2n] of address 3. For n ≥ 16 it sits at bits [2(n-16)+1:2(n-16)] of address 4. The codes are 00 = low level, 01 = high level, 10 = rising edge and 11 = falling edge.
- R7: When bit n of address 7 (both-edges select) is 1, pin n detects both rising and falling edges and its 2-bit code is ignored.
- R8: Status (address 6) is sticky and is set by a detection whatever the mask. Writing 1 to a bit clears it. Writing 0 has no effect.
- R9: If a clear write and a new detection hit the same status bit on the same edge, the bit stays set.
- R10: Address 5 is the interrupt enable mask. `irq` is high one cycle after any bit of (status AND mask) is 1.
- R11: The alias addresses 8 to 10 and unmapped addresses 11 to 15 read as 0. Writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels (asynchronous) |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is R9: a status clear must land on exactly the edge where a fresh detection fires. The two-stage synchronizer and the one-cycle edge history place that detection three edges after a pad change. The directed stimulus reaches it more simply: it holds a high-level pin asserted so that detection fires every cycle, then issues the clear. A long random phase then toggles pads and writes every address. It also hits edge-triggered clear-versus-detect collisions, and the cycle-accurate model scores each of them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFS_DATA    = 0;
  localparam int OFS_DIR     = 1;
  localparam int OFS_PAD     = 2;
  localparam int OFS_SENS_LO = 3;
  localparam int OFS_SENS_HI = 4;
  localparam int OFS_MASK    = 5;
  localparam int OFS_STAT    = 6;
  localparam int OFS_BOTH    = 7;
  localparam int OFS_SET     = 8;
  localparam int OFS_CLR     = 9;
  localparam int OFS_TGL     = 10;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  function automatic logic pin_hit(input logic cur, input logic old,
                                   input logic [1:0] code, input logic any_edge);
    logic r;
    if (any_edge) r = cur ^ old;
    else begin
      case (sense_e'(code))
        SENSE_LOW:  r = ~cur;
        SENSE_HIGH: r = cur;
        SENSE_RISE: r = cur & ~old;
        default:    r = ~cur & old;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   lvl,
  input  logic [2*NPINS-1:0] sens,
  input  logic [NPINS-1:0]   both,
  output logic [NPINS-1:0]   hit
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i] = pin_hit(lvl[i], prev_q[i], sens[2*i +: 2], both[i]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int SENS_W = 2 * NPINS;

  logic [NPINS-1:0]  data_q, dir_q, mask_q, both_q, stat_q, rd_q;
  logic [SENS_W-1:0] sens_q;
  logic              irq_q;
  logic [NPINS-1:0]  pad_s, hit, clr_mask, rd_next;

  logic wr_data, wr_dir, wr_slo, wr_shi, wr_mask, wr_stat, wr_both, wr_set, wr_clr, wr_tgl;
  assign wr_data = bus_we && (bus_addr == ADDR_W'(OFS_DATA));
  assign wr_dir  = bus_we && (bus_addr == ADDR_W'(OFS_DIR));
  assign wr_slo  = bus_we && (bus_addr == ADDR_W'(OFS_SENS_LO));
  assign wr_shi  = bus_we && (bus_addr == ADDR_W'(OFS_SENS_HI));
  assign wr_mask = bus_we && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_both = bus_we && (bus_addr == ADDR_W'(OFS_BOTH));
  assign wr_set  = bus_we && (bus_addr == ADDR_W'(OFS_SET));
  assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
  assign wr_tgl  = bus_we && (bus_addr == ADDR_W'(OFS_TGL));

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_s)
  );

  gpio_edge_det #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .lvl(pad_s), .sens(sens_q), .both(both_q), .hit(hit)
  );

  // Output data with direct load and atomic alias updates
  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (wr_data) data_q <= bus_wdata;
    else if (wr_set)  data_q <= data_q | bus_wdata;
    else if (wr_clr)  data_q <= data_q & ~bus_wdata;
    else if (wr_tgl)  data_q <= data_q ^ bus_wdata;
  end

  // Plain configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      mask_q <= '0;
      both_q <= '0;
      sens_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_both) both_q <= bus_wdata;
      if (wr_slo)  sens_q[NPINS-1:0]      <= bus_wdata;
      if (wr_shi)  sens_q[SENS_W-1:NPINS] <= bus_wdata;
    end
  end

  // Sticky status: a new detection outranks a same-cycle clear
  assign clr_mask = wr_stat ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & mask_q);
  end

  // Registered read path
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_DATA):    rd_next = (data_q & dir_q) | (pad_s & ~dir_q);
      ADDR_W'(OFS_DIR):     rd_next = dir_q;
      ADDR_W'(OFS_PAD):     rd_next = pad_s;
      ADDR_W'(OFS_SENS_LO): rd_next = sens_q[NPINS-1:0];
      ADDR_W'(OFS_SENS_HI): rd_next = sens_q[SENS_W-1:NPINS];
      ADDR_W'(OFS_MASK):    rd_next = mask_q;
      ADDR_W'(OFS_STAT):    rd_next = stat_q;
      ADDR_W'(OFS_BOTH):    rd_next = both_q;
      default:              rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign bus_rdata = rd_q;
  assign pad_out   = data_q;
  assign pad_oe    = dir_q;
  assign irq       = irq_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  mask_q
);
  logic [NPINS-1:0] clr_seen;
  logic             data_touch;
  assign clr_seen   = (bus_we && bus_addr == ADDR_W'(OFS_STAT)) ? bus_wdata : '0;
  assign data_touch = bus_we && (bus_addr == ADDR_W'(OFS_DATA) || bus_addr == ADDR_W'(OFS_SET) ||
                                 bus_addr == ADDR_W'(OFS_CLR)  || bus_addr == ADDR_W'(OFS_TGL));

  p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> pad_oe == $past(bus_wdata));

  p_set_alias_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_SET)) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_CLR)) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

  p_tgl_alias_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_TGL)) |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !data_touch |=> $stable(pad_out));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(stat_q) & ~$past(clr_seen) & ~stat_q) == '0));

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq == $past(|(stat_q & mask_q)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [31:0] m_data, m_dir, m_mask, m_stat, m_both, m_s1, m_s2, m_prev, m_rd;
  logic [63:0] m_sens;
  logic        m_irq;
  string       m_rtag = "R1";

  always @(posedge clk) begin : model
    logic [31:0] det, rdv, clrm;
    logic [1:0]  code;
    started = 1;
    if (rst) begin
      m_data = 0; m_dir = 0; m_mask = 0; m_stat = 0; m_both = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_rd = 0; m_sens = 0; m_irq = 0; m_rtag = "R1";
    end else begin
      rdv = 0;
      case (bus_addr)
        4'd0: begin
          for (int i = 0; i < 32; i++) rdv[i] = m_dir[i] ? m_data[i] : m_s2[i];
          m_rtag = "R4";
        end
        4'd1: begin rdv = m_dir;          m_rtag = "R2";  end
        4'd2: begin rdv = m_s2;           m_rtag = "R5";  end
        4'd3: begin rdv = m_sens[31:0];   m_rtag = "R6";  end
        4'd4: begin rdv = m_sens[63:32];  m_rtag = "R6";  end
        4'd5: begin rdv = m_mask;         m_rtag = "R10"; end
        4'd6: begin rdv = m_stat;         m_rtag = "R8";  end
        4'd7: begin rdv = m_both;         m_rtag = "R7";  end
        default: m_rtag = "R11";
      endcase
      for (int i = 0; i < 32; i++) begin
        code = m_sens[2*i +: 2];
        if (m_both[i])        det[i] = (m_s2[i] != m_prev[i]);
        else if (code == 2'b00) det[i] = (m_s2[i] == 1'b0);
        else if (code == 2'b01) det[i] = (m_s2[i] == 1'b1);
        else if (code == 2'b10) det[i] = m_s2[i] && !m_prev[i];
        else                    det[i] = !m_s2[i] && m_prev[i];
      end
      m_irq  = (m_stat & m_mask) != 0;
      clrm   = (bus_we && bus_addr == 4'd6) ? bus_wdata : 32'h0;
      m_stat = (m_stat & ~clrm) | det;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pad_in;
      if (bus_we) begin
        case (bus_addr)
          4'd0:  m_data = bus_wdata;
          4'd1:  m_dir  = bus_wdata;
          4'd3:  m_sens[31:0]  = bus_wdata;
          4'd4:  m_sens[63:32] = bus_wdata;
          4'd5:  m_mask = bus_wdata;
          4'd7:  m_both = bus_wdata;
          4'd8:  m_data = m_data | bus_wdata;
          4'd9:  m_data = m_data & ~bus_wdata;
          4'd10: m_data = m_data ^ bus_wdata;
          default: ;
        endcase
      end
      m_rd = rdv;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(bus_rdata, m_rd, {m_rtag, " read data"});
      chk(pad_out, m_data, "R3 pad_out");
      chk(pad_oe, m_dir, "R2 pad_oe");
      chk({31'd0, irq}, {31'd0, m_irq}, "R10 irq");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(bus_rdata, 32'h0, "R1 rdata after reset");
    chk(pad_oe, 32'h0, "R1 pad_oe after reset");
    chk({31'd0, irq}, 32'h0, "R1 irq after reset");

    // R2 / R3: direction, data, aliases
    wr(4'd1, 32'h0000_FFFF);
    chk(pad_oe, 32'h0000_FFFF, "R2 direction");
    wr(4'd0, 32'hA5A5_1234);
    chk(pad_out, 32'hA5A5_1234, "R2 data load");
    wr(4'd8, 32'h00F0_000F);
    chk(pad_out, 32'hA5F5_123F, "R3 set alias");
    wr(4'd9, 32'h0000_0101);
    chk(pad_out, 32'hA5F5_123E, "R3 clear alias");
    wr(4'd10, 32'hFFFF_0000);
    chk(pad_out, 32'h5A0A_123E, "R3 toggle alias");

    // R4 / R5: data read mixes, pad read raw synchronized levels
    pad_in = 32'h1234_5678;
    idle(4);
    rd(4'd0);
    chk(bus_rdata, 32'h1234_123E, "R4 data read mix");
    rd(4'd2);
    chk(bus_rdata, 32'h1234_5678, "R5 pad status");

    // R11: aliases and holes read 0, pad register not writable
    rd(4'd9);
    chk(bus_rdata, 32'h0, "R11 alias reads zero");
    rd(4'd15);
    chk(bus_rdata, 32'h0, "R11 unmapped reads zero");
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2);
    chk(bus_rdata, 32'h1234_5678, "R11 pad write ignored");

    // R8: quiet port after clearing (low-level codes, pads high)
    pad_in = 32'hFFFF_FFFF;
    idle(4);
    wr(4'd6, 32'hFFFF_FFFF);
    idle(2);
    rd(4'd6);
    chk(bus_rdata, 32'h0, "R8 cleared status");

    // R6 / R7: pin16 rising, pin17 both-edges (code falling), pin18 falling
    wr(4'd4, 32'h0000_003E);
    wr(4'd7, 32'h0002_0000);
    wr(4'd6, 32'hFFFF_FFFF);
    pad_in = 32'hFFF8_FFFF;
    idle(4);
    rd(4'd6);
    chk(bus_rdata, 32'h0006_0000, "R7 falling pass");
    wr(4'd6, 32'h0);
    rd(4'd6);
    chk(bus_rdata, 32'h0006_0000, "R8 write zero no effect");
    pad_in = 32'hFFFF_FFFF;
    idle(4);
    rd(4'd6);
    chk(bus_rdata, 32'h0007_0000, "R6 rising pass");
    wr(4'd6, 32'h0007_0000);
    rd(4'd6);
    chk(bus_rdata, 32'h0, "R8 write one clears");

    // R6: low-level pin 3 pulses low, status stays after release
    pad_in = 32'hFFFF_FFF7;
    idle(4);
    pad_in = 32'hFFFF_FFFF;
    idle(4);
    rd(4'd6);
    chk(bus_rdata, 32'h0000_0008, "R6 low level sticky");
    wr(4'd6, 32'h0000_0008);

    // R9: pin19 high-level, clear collides with ongoing detection
    wr(4'd4, 32'h0000_007E);
    idle(2);
    wr(4'd6, 32'h0008_0000);
    rd(4'd6);
    chk(bus_rdata, 32'h0008_0000, "R9 detect beats clear");

    // R10: enable and latency of irq
    wr(4'd5, 32'h0008_0000);
    chk({31'd0, irq}, 32'h0, "R10 irq latency");
    idle(1);
    chk({31'd0, irq}, 32'h1, "R10 irq asserted");
    wr(4'd4, 32'h0000_003E);
    wr(4'd6, 32'h0008_0000);
    idle(1);
    chk({31'd0, irq}, 32'h0, "R10 irq released");

    // Random phase, scored by the model each cycle
    for (int n = 0; n < 3000; n++) begin
      bus_we    = ($urandom % 3) != 0;
      bus_addr  = 4'($urandom % 16);
      bus_wdata = $urandom;
      if (($urandom % 4) == 0) pad_in = pad_in ^ ($urandom & $urandom);
      @(negedge clk);
    end
    bus_we = 1'b0;
    idle(2);
    finish_run();
  end
endmodule